// File: doc/BRIEF.md
# Synchronous Serial Receiver with Overrun Lockout

This block is the receive half of a clocked serial port. It collects 8-bit frames from a serial data line, most significant bit first, sampling on each rising edge of the transfer clock, and places each finished frame in a receive data register. The port works either as a clock master, producing the transfer clock from a programmable division of the system clock, or as a slave, taking the transfer clock and an active-low select from outside. In slave mode the external pins are brought into the system clock domain through a two-stage synchronizer. Sampling and frame assembly run on the system clock.

Software controls the block through a small register bus with three locations: data, status and control. Reception starts only after the enable bit is set and the data register has been read once as a dummy read. A receive-full flag marks a waiting byte, and reading the data register clears it.

If a new frame completes while the previous byte is still unread, the block raises an overrun flag. It keeps the old byte, drops the new frame, and stops receiving until software writes the overrun flag to 0. Each flag has its own interrupt output, and each output is gated by its own enable bit.

Top module: `sync_rx_unit`

## Requirements
- R1: After synchronous reset the full flag, the overrun flag, the data register, the control register and both interrupt outputs are 0, and `sclk_out` is 1.
- R2: A frame is accepted only when control bit 0 (receive enable) is 1 and the data register (address 0) has been read while that bit was 1. Clearing bit 0 disarms the block, so a later re-enable needs a new dummy read.
- R3: A frame is 8 bits, MSB first, each bit sampled on a rising edge of the transfer clock. On the 8th bit the byte is loaded into the data register and the full flag (status bit 0) is set to 1.
- R4: In slave mode (control bit 3 = 0) bits are taken from `sclk_in` edges only while `ss_n` is low. Raising `ss_n` part-way through a frame discards the bits collected so far.
- R5: In master mode (control bit 3 = 1) `sclk_out` gives 8 low-then-high pulses per frame. Each half period lasts (control bits 7:4) + 3 system clocks, and `sclk_out` rests high outside frames and whenever master mode is off.
- R6: A bus read of the data register clears the full flag.
- R7: If a frame completes while the full flag is 1, the overrun flag (status bit 1) becomes 1. The data register keeps the earlier byte, the new frame is lost, and the full flag stays 1.
- R8: While the overrun flag is 1 no frame is received and the master clock stops. A status write with bit 1 = 0 clears the flag and reception resumes. A status write with bit 1 = 1 leaves it unchanged.
- R9: `irq_rx` equals the full flag ANDed with control bit 1, one system clock later.
- R10: `irq_ovr` equals the overrun flag ANDed with control bit 2, one system clock later.
- R11: A read returns on `bus_rdata` one clock after `bus_rd` is asserted. Address 0 returns the data register, address 1 returns {6'b0, overrun, full}, address 2 returns the control register, and address 3 returns 0. Writes go to address 2 (control) and address 1 (overrun clear).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sclk_out | output | 1 | Transfer clock driven in master mode, idles high |
| sclk_in | input | 1 | Transfer clock from outside in slave mode |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
A bit counter that slips by one position shows up on the first affected frame: a whole frame later the read-back byte is rotated, or the full flag comes up one edge early or late compared with the count of `sclk_out` rising edges. An arming flag or overrun flag stuck in the wrong state shows within one frame. A frame is accepted when it should be dropped, or dropped when it should be accepted, and a status read a few clocks after the last edge shows this. A master clock that keeps running during overrun shows as extra `sclk_out` edges within one half period.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = 4;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  localparam int ST_FULL_BIT = 0;
  localparam int ST_OVR_BIT  = 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             master;
    logic             ovr_ie;
    logic             rx_ie;
    logic             rx_en;
  } ctrl_t;

  typedef enum logic [1:0] {MC_IDLE, MC_LOW, MC_HIGH} mclk_st_t;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sr_mclk.sv
module sr_mclk
  import sr_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise
);
  localparam int CNT_W = DIV_W + 2;
  localparam int NB_W  = $clog2(FRAME_W + 1);

  mclk_st_t         st;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] half_m1;
  logic [NB_W-1:0]  nbit;

  assign half_m1 = CNT_W'(div) + CNT_W'(2);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st   <= MC_IDLE;
      sclk <= 1'b1;
      tick <= '0;
      nbit <= '0;
      rise <= 1'b0;
    end else begin
      rise <= 1'b0;
      case (st)
        MC_IDLE: begin
          sclk <= 1'b0;
          tick <= '0;
          nbit <= '0;
          st   <= MC_LOW;
        end
        MC_LOW: begin
          if (tick == half_m1) begin
            sclk <= 1'b1;
            rise <= 1'b1;
            tick <= '0;
            nbit <= nbit + 1'b1;
            st   <= MC_HIGH;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        MC_HIGH: begin
          if (tick == half_m1) begin
            tick <= '0;
            if (nbit == NB_W'(FRAME_W)) begin
              st <= MC_IDLE;
            end else begin
              sclk <= 1'b0;
              st   <= MC_LOW;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: st <= MC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sr_frame.sv
module sr_frame #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               smp,
  input  logic               bit_in,
  output logic               done,
  output logic [FRAME_W-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sh   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (smp) begin
        sh <= {sh[FRAME_W-2:0], bit_in};
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign word = sh;
endmodule

// File: rtl/sr_regs.sv
module sr_regs
  import sr_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               done,
  input  logic [FRAME_W-1:0] word,
  output ctrl_t              ctrl_q,
  output logic [FRAME_W-1:0] data_q,
  output logic               full_q,
  output logic               ovr_q,
  output logic               armed_q,
  output logic               data_rd,
  output logic               irq_rx,
  output logic               irq_ovr
);
  logic full_eff;
  logic stat_wr;
  logic [BUS_W-1:0] stat_word;

  assign data_rd   = bus_rd && (bus_addr == A_DATA);
  assign stat_wr   = bus_wr && (bus_addr == A_STAT);
  assign full_eff  = full_q && !data_rd;
  assign stat_word = BUS_W'({ovr_q, full_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      full_q    <= 1'b0;
      ovr_q     <= 1'b0;
      armed_q   <= 1'b0;
      bus_rdata <= '0;
      irq_rx    <= 1'b0;
      irq_ovr   <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == A_CTRL)) ctrl_q <= ctrl_t'(bus_wdata);

      if (!ctrl_q.rx_en)  armed_q <= 1'b0;
      else if (data_rd)   armed_q <= 1'b1;

      full_q <= full_eff;
      if (stat_wr && !bus_wdata[ST_OVR_BIT]) ovr_q <= 1'b0;

      if (done) begin
        if (full_eff) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= word;
          full_q <= 1'b1;
        end
      end

      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= BUS_W'(data_q);
          A_STAT:  bus_rdata <= stat_word;
          A_CTRL:  bus_rdata <= BUS_W'(ctrl_q);
          default: bus_rdata <= '0;
        endcase
      end

      irq_rx  <= full_q && ctrl_q.rx_ie;
      irq_ovr <= ovr_q && ctrl_q.ovr_ie;
    end
  end
endmodule

// File: rtl/sync_rx_unit.sv
module sync_rx_unit
  import sr_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sclk_out,
  input  logic              sclk_in,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              irq_rx,
  output logic              irq_ovr
);
  ctrl_t              ctrl_q;
  logic [FRAME_W-1:0] data_q;
  logic [FRAME_W-1:0] fr_word;
  logic               full_q, ovr_q, armed_q, data_rd;
  logic               fr_done, fr_en, fr_smp;
  logic               active, mode_master;
  logic               m_rise, s_rise;
  logic               sclk_s, ssn_s, sdi_s, sclk_d;

  sr_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync_ctl (
    .clk(clk), .rst(rst), .d({ss_n, sclk_in}), .q({ssn_s, sclk_s})
  );

  sr_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_dat (
    .clk(clk), .rst(rst), .d(sdi), .q(sdi_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b1;
    else     sclk_d <= sclk_s;
  end

  assign s_rise      = sclk_s && !sclk_d;
  assign mode_master = ctrl_q.master;
  assign active      = ctrl_q.rx_en && armed_q && !ovr_q;

  sr_mclk #(.FRAME_W(FRAME_W)) u_mclk (
    .clk(clk), .rst(rst), .run(active && mode_master), .div(ctrl_q.div),
    .sclk(sclk_out), .rise(m_rise)
  );

  assign fr_en  = mode_master ? active : (active && !ssn_s);
  assign fr_smp = mode_master ? m_rise : s_rise;

  sr_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst), .en(fr_en), .smp(fr_smp), .bit_in(sdi_s),
    .done(fr_done), .word(fr_word)
  );

  sr_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(fr_done), .word(fr_word),
    .ctrl_q(ctrl_q), .data_q(data_q), .full_q(full_q), .ovr_q(ovr_q),
    .armed_q(armed_q), .data_rd(data_rd),
    .irq_rx(irq_rx), .irq_ovr(irq_ovr)
  );
endmodule

// File: rtl/sr_chk.sv
module sr_chk #(
  parameter int FRAME_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               full,
  input logic               ovr,
  input logic               armed,
  input logic               data_rd,
  input logic               done,
  input logic [FRAME_W-1:0] data_q,
  input logic               irq_rx,
  input logic               irq_ovr,
  input logic               sclk_out,
  input logic               master
);
  logic rst_seen;

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      AST_RESET_CLEAR: assert (!full && !ovr && !irq_rx && !irq_ovr && sclk_out) else $error("reset state"); // R1
    end
    rst_seen <= rst;
  end

  AST_NOT_ARMED: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !done); // R2

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!master && !$past(master)) |-> sclk_out); // R5

  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !done) |=> !full); // R6

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (done && full && !data_rd) |=> (ovr && full && $stable(data_q))); // R7

  AST_NO_RX_IN_OVR: assert property (@(posedge clk) disable iff (rst)
    ovr |-> !done); // R8

  AST_IRQ_RX_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_rx) |-> $past(full)); // R9

  AST_IRQ_OVR_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ovr) |-> $past(ovr)); // R10
endmodule

bind sync_rx_unit sr_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .full(full_q), .ovr(ovr_q), .armed(armed_q),
  .data_rd(data_rd), .done(fr_done), .data_q(data_q),
  .irq_rx(irq_rx), .irq_ovr(irq_ovr), .sclk_out(sclk_out),
  .master(mode_master)
);

// File: tb/sim_sync_rx_unit.sv
`timescale 1ns/1ps
module sim_sync_rx_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk_out, sclk_in = 1'b1, ss_n = 1'b1;
  logic       sdi_s = 1'b0, sdi_m = 1'b0, use_m = 1'b0;
  logic       irq_rx, irq_ovr;
  wire        sdi = use_m ? sdi_m : sdi_s;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_rx_unit u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_out(sclk_out),
    .sclk_in(sclk_in), .ss_n(ss_n), .sdi(sdi), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
  );

  // master-mode partner: shifts out bytes on falling edges of sclk_out
  logic [7:0] m_bytes [16];
  int m_idx = 0, m_bit = 0, rise_cnt = 0;
  logic [7:0] m_cur;
  always @(negedge sclk_out) begin
    if (m_bit == 0) m_cur = m_bytes[m_idx];
    sdi_m = m_cur[7 - m_bit];
    m_bit = m_bit + 1;
    if (m_bit == 8) begin m_bit = 0; m_idx = m_idx + 1; end
  end
  always @(posedge sclk_out) rise_cnt = rise_cnt + 1;

  // bench model of the flags and data register
  logic [7:0] md_data = '0;
  logic       md_full = 0, md_ovr = 0;

  function automatic logic [9:0] model_frame(logic [9:0] st, logic [7:0] b);
    // st = {ovr, full, data}
    if (st[9]) return st;
    if (st[8]) return {1'b1, st[8:0]};
    return {2'b01, b};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    finished = 1;
    $finish;
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic slave_frame(input logic [7:0] b, input int nbits, input logic sel);
    @(negedge clk); ss_n = ~sel;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sclk_in = 0; sdi_s = b[7 - i];
      repeat (4) @(negedge clk); sclk_in = 1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk); ss_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_stat_bit(input int bitn, output bit ok);
    logic [7:0] v;
    ok = 0;
    for (int i = 0; i < 600; i++) begin
      bread(2'd1, v);
      if (v[bitn]) begin ok = 1; return; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    logic [9:0] ms;
    bit ok;
    int lowc, rc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_bytes[i] = 8'($urandom);

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 irq", {irq_rx, irq_ovr}, 0);
    bread(2'd1, v); chk("R1 status", v, 0);
    bread(2'd2, v); chk("R1 ctrl", v, 0);

    // R11 control readback, R2 not armed without dummy read
    bwrite(2'd2, 8'h01);
    bread(2'd2, v); chk("R11 ctrl readback", v, 8'h01);
    bread(2'd3, v); chk("R11 unused addr", v, 8'h00);
    slave_frame(8'hA5, 8, 1);
    bread(2'd1, v); chk("R2 no rx before dummy read", v, 0);

    // R3 basic reception after arming
    bread(2'd0, v);
    slave_frame(8'h3C, 8, 1);
    bread(2'd1, v); chk("R3 full set", v, 8'h01);
    chk("R9 irq_rx off when disabled", irq_rx, 0);
    bread(2'd0, v); chk("R3 data msb first", v, 8'h3C);
    bread(2'd1, v); chk("R6 read clears full", v, 0);

    // R4 select high ignored; partial frame discarded
    slave_frame(8'hE7, 8, 0);
    bread(2'd1, v); chk("R4 ss_n high ignored", v, 0);
    slave_frame(8'hFF, 5, 1);
    slave_frame(8'h81, 8, 1);
    bread(2'd0, v); chk("R4 partial discarded", v, 8'h81);

    // R7/R8/R9/R10 overrun with interrupts enabled
    bwrite(2'd2, 8'h07);
    slave_frame(8'h5A, 8, 1);
    chk("R9 irq_rx", irq_rx, 1);
    slave_frame(8'hC3, 8, 1);
    bread(2'd1, v); chk("R7 ovr and full", v, 8'h03);
    chk("R10 irq_ovr", irq_ovr, 1);
    slave_frame(8'h11, 8, 1);
    bread(2'd0, v); chk("R7 data kept R8 ignored", v, 8'h5A);
    bwrite(2'd1, 8'h02);
    bread(2'd1, v); chk("R8 write 1 keeps ovr", v, 8'h02);
    bwrite(2'd1, 8'h00);
    repeat (2) @(negedge clk);
    bread(2'd1, v); chk("R8 ovr cleared", v, 8'h00);
    chk("R10 irq_ovr low", irq_ovr, 0);
    slave_frame(8'h99, 8, 1);
    bread(2'd0, v); chk("R8 resume", v, 8'h99);

    // R2 disarm on enable clear
    bwrite(2'd2, 8'h00);
    bwrite(2'd2, 8'h07);
    slave_frame(8'h44, 8, 1);
    bread(2'd1, v); chk("R2 disarmed", v, 0);

    // random slave traffic vs bench model
    bread(2'd0, v);
    md_full = 0; md_ovr = 0; md_data = 8'h99;
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom % 5);
      if (op <= 1) begin
        logic [7:0] b; logic sel;
        b = 8'($urandom); sel = ($urandom % 4) != 0;
        slave_frame(b, 8, sel);
        if (sel) begin
          ms = model_frame({md_ovr, md_full, md_data}, b);
          {md_ovr, md_full, md_data} = ms;
        end
      end else if (op == 2) begin
        bread(2'd0, v); chk("R3 random data", v, md_data);
        md_full = 0;
      end else if (op == 3) begin
        bread(2'd1, v); chk("R7 random status", v, {6'b0, md_ovr, md_full});
        chk("R9 random irq_rx", irq_rx, md_full);
        chk("R10 random irq_ovr", irq_ovr, md_ovr);
      end else begin
        bwrite(2'd1, 8'h00); md_ovr = 0;
      end
    end
    bwrite(2'd2, 8'h00);
    bwrite(2'd1, 8'h00);
    bread(2'd0, v);

    // master mode, several dividers
    use_m = 1;
    for (int dv = 0; dv < 4; dv++) begin
      if (dv == 2) continue;
      m_idx = 0; m_bit = 0; rise_cnt = 0;
      bwrite(2'd2, {4'(dv), 4'b1001});
      bread(2'd0, v);
      lowc = 0;
      while (sclk_out) @(negedge clk);
      while (!sclk_out) begin lowc++; @(negedge clk); end
      chk("R5 half period", lowc, dv + 3);
      wait_stat_bit(0, ok); chk("R3 master frame", ok, 1);
      chk("R5 8 pulses", rise_cnt, 8);
      bread(2'd0, v); chk("R3 master data0", v, m_bytes[0]);
      for (int k = 1; k < 3; k++) begin
        wait_stat_bit(0, ok);
        bread(2'd0, v); chk("R3 master data", v, m_bytes[k]);
      end
      if (dv == 1) begin
        wait_stat_bit(1, ok); chk("R7 master ovr", ok, 1);
        rc = rise_cnt;
        repeat (100) @(negedge clk);
        chk("R8 master clock stopped", rise_cnt, rc);
        chk("R5 idle high", sclk_out, 1);
        bread(2'd0, v); chk("R7 master data kept", v, m_bytes[3]);
        bwrite(2'd1, 8'h00);
        wait_stat_bit(0, ok);
        bread(2'd0, v); chk("R8 master resume", v, m_bytes[5]);
      end
      bwrite(2'd2, 8'h00);
      repeat (60) @(negedge clk);
      chk("R5 idle after stop", sclk_out, 1);
      bwrite(2'd1, 8'h00);
      bread(2'd0, v);
    end
    report();
  end
endmodule